// File: doc/BRIEF.md
# Latching On-Delay Timer with Retention

This timer measures a programmable interval after a single trigger pulse and then latches its output high. The trigger input needs to be high for only one clock cycle. The block detects the rising edge and runs the interval on its own from then on. Time advances only on cycles where a tick-enable strobe is high, so one shared prescaler can pace many such timers. The output stays high until the clear input is asserted.

A power-restore strobe models the return of supply after an outage. When the retain mode bit is low, this strobe wipes the interval in progress and the output. When the bit is high, the elapsed count and the output come through unchanged, and counting continues from where it stopped. The duration input is read on every tick, so it can be changed while an interval is running.

Top module: `ondelay_latch_timer`

## Requirements
- R1: A rising edge on `trig` (high now, low in the previous cycle) while the timer is idle and `q` is low starts an interval. `trig` may fall in the next cycle.
- R2: For `dur` = D ≥ 1, `q` goes high at the clock edge of the D-th counted tick and not earlier.
- R3: `clr` high at a clock edge clears the elapsed count, stops any running interval, and makes `q` low after that edge.
- R4: When `clr` and a `trig` rising edge fall in the same cycle, `clr` wins and no interval starts.
- R5: Once `q` is high, it stays high through any further trigger pulses or ticks until `clr` is asserted.
- R6: A `trig` rising edge during a running interval neither restarts nor extends it.
- R7: The count advances only on cycles where `tick` is high. A tick in the same cycle as the starting edge is not counted.
- R8: With `dur` = 0, `q` goes high at the first counted tick after the start.
- R9: `dur` is compared on every tick as the count advances. If `dur` is lowered to or below the elapsed count, the interval expires on the next tick.
- R10: `pwr_restore` high with `retain` = 0 clears the count, the running interval and `q`.
- R11: `pwr_restore` high with `retain` = 1 leaves the count, the running interval and `q` unchanged, and counting resumes.
- R12: Asynchronous active-low `rst_n` clears all state. `q` is 0 during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; one count per high cycle |
| trig | input | 1 | Trigger; a rising edge starts an interval |
| clr | input | 1 | Clear of count and output; overrides the trigger |
| dur | input | CNT_W | Interval length in ticks |
| retain | input | 1 | 1 = state survives a power-restore event |
| pwr_restore | input | 1 | Strobe marking return of supply |
| q | output | 1 | Latched timer output |

## Verification
A table of durations (0, 1, short, long) is driven with the ticks back to back and with idle gaps between them. This separates counting ticks from counting clock cycles, and it shows the zero case. Directed sequences cover four more cases:
- a second trigger pulse mid-interval, which would show up as a restart;
- `dur` lowered mid-run, which separates a greater-or-equal compare from an equality compare;
- a trigger in the same cycle as `clr`, which shows the priority order;
- a power-restore event under each `retain` setting, which separates a wiped interval from a resumed one by the tick on which `q` rises.

// File: rtl/ondelay_latch_timer.sv
module ondelay_latch_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic             clr,
  input  logic [CNT_W-1:0] dur,
  input  logic             retain,
  input  logic             pwr_restore,
  output logic             q
);

  logic [CNT_W-1:0] elapsed;
  logic             running;
  logic             q_r;
  logic             trig_q;

  wire             wipe     = clr | (pwr_restore & ~retain);
  wire             start    = trig & ~trig_q & ~running & ~q_r;
  wire [CNT_W:0]   next_cnt = {1'b0, elapsed} + (CNT_W+1)'(1);
  wire             expire   = next_cnt >= {1'b0, dur};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      running <= 1'b0;
      q_r     <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= trig;
      if (wipe) begin
        elapsed <= '0;
        running <= 1'b0;
        q_r     <= 1'b0;
      end else if (start) begin
        elapsed <= '0;
        running <= 1'b1;
      end else if (running && tick) begin
        if (expire) begin
          q_r     <= 1'b1;
          running <= 1'b0;
          elapsed <= '0;
        end else begin
          elapsed <= next_cnt[CNT_W-1:0];
        end
      end
    end
  end

  assign q = q_r;

endmodule

// File: rtl/ondelay_latch_timer_chk.sv
module ondelay_latch_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             clr,
  input logic             retain,
  input logic             pwr_restore,
  input logic             q,
  input logic             running,
  input logic [CNT_W-1:0] elapsed
);

  p_clr_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!q && !running && elapsed == '0));

  p_clr_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !running);

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr && !(pwr_restore && !retain)) |=> q);

  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> ($past(tick) && $past(running)));

  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !pwr_restore) |=> $stable(elapsed));

  p_volatile_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_restore && !retain) |=> (!q && !running));

  p_retained_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_restore && retain && !clr && !tick) |=> ($stable(elapsed) && $stable(running) && $stable(q)));

endmodule

bind ondelay_latch_timer ondelay_latch_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .retain(retain),
  .pwr_restore(pwr_restore), .q(q), .running(running), .elapsed(elapsed)
);

// File: tb/sim_ondelay_latch_timer.sv
module sim_ondelay_latch_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NV = 6;
  // {dur, idle cycles between ticks, tick on which q must rise}
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 0, 1}, '{1, 0, 1}, '{3, 0, 3}, '{5, 2, 5}, '{2, 3, 2}, '{7, 1, 7}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, trig = 1'b0, clr = 1'b0;
  logic retain = 1'b0, pwr_restore = 1'b0;
  logic [CNT_W-1:0] dur = '0;
  logic q;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ondelay_latch_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .clr(clr),
    .dur(dur), .retain(retain), .pwr_restore(pwr_restore), .q(q)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick(input int gap);
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(gap);
  endtask

  task automatic do_trig();
    trig = 1'b1; cyc(1); trig = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk(q, 1'b0, "R12 in reset");
    rst_n = 1'b1; cyc(1);
    chk(q, 1'b0, "R12 after reset");

    // table walk: R1 R2 R7 R8
    for (int i = 0; i < NV; i++) begin
      do_clr();
      dur = CNT_W'(VEC[i][0]);
      do_trig();
      for (int k = 1; k <= VEC[i][2]; k++) begin
        do_tick(VEC[i][1]);
        chk(q, (k == VEC[i][2]), (VEC[i][0] == 0) ? "R8 zero dur" : "R2 expiry tick");
      end
    end

    // R5: latched against trigger and ticks
    do_trig(); cyc(1); do_tick(0); do_tick(0);
    chk(q, 1'b1, "R5 hold after trig");
    // R3: clear drops q and stops timing
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk(q, 1'b0, "R3 clear");
    do_tick(0); do_tick(0); do_tick(0);
    chk(q, 1'b0, "R3 stays clear");

    // R4: clear and trigger together
    dur = 16'd2;
    trig = 1'b1; clr = 1'b1; cyc(1); trig = 1'b0; clr = 1'b0;
    repeat (4) do_tick(0);
    chk(q, 1'b0, "R4 clr over trig");

    // R6: retrigger mid-run
    do_clr(); dur = 16'd4;
    do_trig(); do_tick(0); do_tick(0);
    do_trig(); do_tick(0);
    chk(q, 1'b0, "R6 before 4th tick");
    do_tick(0);
    chk(q, 1'b1, "R6 no restart");

    // R7: tick in start cycle not counted, idle cycles do nothing
    do_clr(); dur = 16'd2;
    trig = 1'b1; tick = 1'b1; cyc(1); trig = 1'b0; tick = 1'b0;
    cyc(20);
    do_tick(0);
    chk(q, 1'b0, "R7 start tick ignored");
    do_tick(0);
    chk(q, 1'b1, "R7 second tick");

    // R9: duration lowered mid-run
    do_clr(); dur = 16'd10;
    do_trig(); do_tick(0); do_tick(0); do_tick(0);
    chk(q, 1'b0, "R9 before change");
    dur = 16'd2;
    do_tick(0);
    chk(q, 1'b1, "R9 lowered dur");

    // R10: volatile restore
    do_clr(); dur = 16'd3; retain = 1'b0;
    do_trig(); do_tick(0); do_tick(0);
    pwr_restore = 1'b1; cyc(1); pwr_restore = 1'b0;
    repeat (4) do_tick(0);
    chk(q, 1'b0, "R10 interval wiped");
    do_trig(); repeat (3) do_tick(0);
    chk(q, 1'b1, "R10 setup high");
    pwr_restore = 1'b1; cyc(1); pwr_restore = 1'b0;
    chk(q, 1'b0, "R10 output wiped");

    // R11: retained restore
    do_clr(); dur = 16'd4; retain = 1'b1;
    do_trig(); do_tick(0); do_tick(0);
    pwr_restore = 1'b1; cyc(1); pwr_restore = 1'b0;
    do_tick(0);
    chk(q, 1'b0, "R11 resume 3rd tick");
    do_tick(0);
    chk(q, 1'b1, "R11 resume 4th tick");
    pwr_restore = 1'b1; cyc(1); pwr_restore = 1'b0;
    chk(q, 1'b1, "R11 output kept");

    // R12: async reset mid-run
    do_clr(); dur = 16'd3; retain = 1'b0;
    do_trig(); do_tick(0);
    rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
    repeat (4) do_tick(0);
    chk(q, 1'b0, "R12 reset mid-run");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule